// File: doc/BRIEF.md
# Vector Memory Transaction Sequencer

This block turns one decoded vector load or store instruction into the series of requests that a fixed-width memory port needs. A decoded command gives the access kind, the element width, the vector length, a base address, a signed byte stride and a field count. The block then issues requests. Each request carries an address, byte enables and, for stores, write data placed on the correct byte lanes. Alongside each request it reports which element and which field the request serves, so that a load return can be written back to the right place. Indexed accesses take one byte offset per element from a separate stream. Stores take one data word per request from a store-data stream.

Two paths exist. When the base address sits on a port-width boundary, unit-stride accesses, single-field segment accesses and whole-register accesses use the packed path, which fills every beat with as many elements as fit. Every other case takes the element-serial path and issues one request per element, or per element and field. This includes a unit-stride or whole-register access whose base is off the boundary, and all strided, indexed and multi-field segment accesses. A one-cycle done pulse follows the acceptance of the final request.

Top module: `vls_txn_gen`

## Requirements
- R1: The element width code `cmd_ew` selects 8 bits (0), 16 bits (1) or 32 bits (2). On the serial path each request enables exactly that many bytes, starting at lane `mem_addr % PORT_BYTES`. Elements are assumed to be aligned to their own size.
- R2: A unit-stride access (kind 0) whose base is a multiple of `PORT_BYTES` issues beats at base + k*`PORT_BYTES`. Each beat holds `PORT_BYTES`/element-size elements. The access takes ceil(vl / elements-per-beat) beats.
- R3: On the packed path, a final beat that holds fewer elements than a full beat enables only the low remaining-elements × element-size bytes.
- R4: A unit-stride access with a base that is not a multiple of `PORT_BYTES` issues one request per element, at base + i*element-size.
- R5: A strided access (kind 1) issues one request per element, at base + i*`cmd_stride`. The stride is a signed byte count and the sum wraps modulo 2^32.
- R6: An indexed access (kind 2) issues one request per element, at base + `idx_offset` (modulo 2^32). It consumes exactly one offset, with `idx_ready`, per accepted request.
- R7: A segment access (kind 3) with `cmd_nf` = F-1 > 0 issues requests in the order element 0 fields 0..F-1, then element 1, and so on. The request for element i, field f goes to base + (i*F + f)*element-size. With `cmd_nf` = 0 a segment access behaves exactly as a unit-stride access.
- R8: A whole-register access (kind 4) moves (`cmd_nf`+1)*`VLEN_BYTES`/element-size elements and ignores `cmd_vl`. It uses the packed path when the base is port-aligned and the serial path otherwise.
- R9: A request stays on offer with an unchanged address until `mem_ready` accepts it. Addresses and counters advance only on acceptance.
- R10: `cmd_ready` is low from command acceptance until the final request is accepted. `done` pulses for one cycle in the cycle after the final acceptance. A command with zero length issues no request and pulses `done` in the cycle after it is accepted.
- R11: For stores, the serial path moves the element from the low bytes of `st_data` onto its lanes, and the packed path passes `st_data` through. In both cases disabled bytes are zero, and one store word is consumed per accepted request. For loads, `mem_we` is low and `mem_wdata` is zero.
- R12: `wb_elem` gives the index of the first element carried by the request and `wb_field` gives its field number.
- R13: During and after reset, `mem_valid` and `done` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken |
| cmd_kind | input | 3 | 0 unit, 1 strided, 2 indexed, 3 segment, 4 whole-register |
| cmd_ew | input | 2 | Element width code |
| cmd_store | input | 1 | 1 for store, 0 for load |
| cmd_vl | input | VL_W | Vector length in elements |
| cmd_base | input | ADDR_W | Base byte address |
| cmd_stride | input | ADDR_W | Signed byte stride |
| cmd_nf | input | 3 | Field count minus one |
| idx_valid | input | 1 | Index offset available |
| idx_ready | output | 1 | Index offset consumed |
| idx_offset | input | ADDR_W | Byte offset for the current element |
| st_valid | input | 1 | Store word available |
| st_ready | output | 1 | Store word consumed |
| st_data | input | 8*PORT_BYTES | Store word |
| mem_valid | output | 1 | Request offered |
| mem_ready | input | 1 | Request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_be | output | PORT_BYTES | Byte enables |
| mem_wdata | output | 8*PORT_BYTES | Lane-placed write data |
| wb_elem | output | VL_W | First element index of the request |
| wb_field | output | 3 | Field number of the request |
| done | output | 1 | Final request accepted last cycle |

## Verification
The hardest situation to reach is a request that stalls while one of its side streams drops out. This happens when `mem_ready` is low and `idx_valid` or `st_valid` is withdrawn in the middle of a segment or tail beat. The requirement is that neither the address nor the element or field counters slip. The stimulus throttles `mem_ready`, `idx_valid` and `st_valid` independently at random every cycle, across many commands of random kind, width, length, alignment and stride. Directed cases then force port-aligned tails, bases that are only element-aligned, negative strides that wrap past address zero, single-field segments and zero length.

// File: rtl/vls_pkg.sv
// Shared types for the vector memory transaction sequencer.
package vls_pkg;
    typedef enum logic [2:0] {
        KIND_UNIT     = 3'd0,
        KIND_STRIDED  = 3'd1,
        KIND_INDEXED  = 3'd2,
        KIND_SEGMENT  = 3'd3,
        KIND_WHOLE    = 3'd4
    } vls_kind_e;
endpackage

// File: rtl/vls_plan.sv
// Combinational command planner: picks the packed or serial path, the total
// element count and the effective field count for a new command.
// Assumes cmd_ew is 0..2 and whole-register counts fit in VL_W bits.
module vls_plan
    import vls_pkg::*;
#(
    parameter int PORT_BYTES = 8,
    parameter int VLEN_BYTES = 32,
    parameter int VL_W       = 9
) (
    input  vls_kind_e                      kind,
    input  logic [1:0]                     ew,
    input  logic [VL_W-1:0]                vl,
    input  logic [$clog2(PORT_BYTES)-1:0]  base_lo,
    input  logic [2:0]                     nf,
    output logic                           packed_mode,
    output logic [VL_W-1:0]                total,
    output logic [2:0]                     nf_eff
);
    logic [31:0] whole_cnt;
    logic        packable;

    // Decide path, element count and field count.
    always_comb begin
        whole_cnt   = ((32'(nf) + 32'd1) * 32'(VLEN_BYTES)) >> ew;
        packable    = (kind == KIND_UNIT) || (kind == KIND_WHOLE) ||
                      ((kind == KIND_SEGMENT) && (nf == 3'd0));
        packed_mode = packable && (base_lo == '0);
        total       = (kind == KIND_WHOLE) ? whole_cnt[VL_W-1:0] : vl;
        nf_eff      = (kind == KIND_SEGMENT) ? nf : 3'd0;
    end
endmodule

// File: rtl/vls_seq.sv
// Sequencer: holds the running command, steps address, element and field
// counters on each accepted request and raises done after the last one.
// Assumes mem_valid is only high while busy.
module vls_seq
    import vls_pkg::*;
#(
    parameter int PORT_BYTES = 8,
    parameter int VL_W       = 9,
    parameter int ADDR_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_fire,
    input  logic               plan_packed,
    input  logic [VL_W-1:0]    plan_total,
    input  logic [2:0]         plan_nf,
    input  vls_kind_e          cmd_kind,
    input  logic [1:0]         cmd_ew,
    input  logic               cmd_store,
    input  logic [ADDR_W-1:0]  cmd_base,
    input  logic [ADDR_W-1:0]  cmd_stride,
    input  logic               mem_valid,
    input  logic               mem_ready,
    output logic               busy,
    output logic               packed_q,
    output vls_kind_e          kind_q,
    output logic [1:0]         ew_q,
    output logic               store_q,
    output logic [ADDR_W-1:0]  base_q,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [VL_W-1:0]    elem_q,
    output logic [2:0]         field_q,
    output logic [VL_W-1:0]    total_q,
    output logic               done
);
    localparam int LANE_W = $clog2(PORT_BYTES);

    logic [ADDR_W-1:0] stride_q;
    logic [2:0]        nf_q;
    logic [VL_W:0]     epb;
    logic [ADDR_W-1:0] esz;
    logic              last;
    logic              mem_fire;

    // Derive per-beat quantities and the last-request flag.
    always_comb begin
        epb      = (VL_W+1)'(PORT_BYTES >> ew_q);
        esz      = ADDR_W'(1) << ew_q;
        mem_fire = busy && mem_valid && mem_ready;
        if (packed_q)
            last = (({1'b0, elem_q} + epb) >= {1'b0, total_q});
        else
            last = (elem_q == (total_q - 1'b1)) && (field_q == nf_q);
    end

    // Load a command, then step counters on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            packed_q <= 1'b0;
            kind_q   <= KIND_UNIT;
            ew_q     <= 2'd0;
            store_q  <= 1'b0;
            base_q   <= '0;
            stride_q <= '0;
            cur_addr <= '0;
            elem_q   <= '0;
            field_q  <= 3'd0;
            nf_q     <= 3'd0;
            total_q  <= '0;
        end else begin
            done <= 1'b0;
            if (cmd_fire) begin
                packed_q <= plan_packed;
                kind_q   <= cmd_kind;
                ew_q     <= cmd_ew;
                store_q  <= cmd_store;
                base_q   <= cmd_base;
                stride_q <= cmd_stride;
                cur_addr <= cmd_base;
                elem_q   <= '0;
                field_q  <= 3'd0;
                nf_q     <= plan_nf;
                total_q  <= plan_total;
                if (plan_total == '0)
                    done <= 1'b1;
                else
                    busy <= 1'b1;
            end else if (mem_fire) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (packed_q) begin
                    elem_q   <= elem_q + epb[VL_W-1:0];
                    cur_addr <= cur_addr + ADDR_W'(PORT_BYTES);
                end else if (field_q != nf_q) begin
                    field_q  <= field_q + 3'd1;
                    cur_addr <= cur_addr + esz;
                end else begin
                    field_q  <= 3'd0;
                    elem_q   <= elem_q + 1'b1;
                    cur_addr <= cur_addr + ((kind_q == KIND_STRIDED) ? stride_q : esz);
                end
            end
        end
    end

    assert_packed_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && packed_q) |-> (cur_addr[LANE_W-1:0] == '0));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_valid && !mem_ready) |=>
        (busy && $stable(cur_addr) && $stable(elem_q) && $stable(field_q)));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_elem_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (elem_q < total_q) && (field_q <= nf_q));
endmodule

// File: rtl/vls_lane.sv
// Lane shaper: forms byte enables and lane-placed write data for the request
// on offer. Assumes serial elements do not straddle a port-width boundary.
module vls_lane #(
    parameter int PORT_BYTES = 8,
    parameter int VL_W       = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           active,
    input  logic                           packed_mode,
    input  logic [1:0]                     ew,
    input  logic [$clog2(PORT_BYTES)-1:0]  lane_off,
    input  logic [VL_W-1:0]                elem,
    input  logic [VL_W-1:0]                total,
    input  logic                           store,
    input  logic [8*PORT_BYTES-1:0]        st_data,
    output logic [PORT_BYTES-1:0]          be,
    output logic [8*PORT_BYTES-1:0]        wdata
);
    localparam int LANE_W = $clog2(PORT_BYTES);

    logic [VL_W-1:0]   rem;
    logic [VL_W+2:0]   rem_bytes;
    logic [LANE_W-1:0] shift;

    // Compute enables and place store bytes on their lanes.
    always_comb begin
        rem       = total - elem;
        rem_bytes = {3'b000, rem} << ew;
        shift     = packed_mode ? '0 : lane_off;
        for (int b = 0; b < PORT_BYTES; b++) begin
            logic [LANE_W-1:0] src;
            if (packed_mode)
                be[b] = ((VL_W+3)'(b) < rem_bytes);
            else
                be[b] = (b >= int'(lane_off)) && (b < (int'(lane_off) + (1 << ew)));
            src = LANE_W'(b) - shift;
            wdata[b*8 +: 8] = (store && be[b]) ? st_data[{src, 3'b000} +: 8] : 8'h00;
        end
    end

    assert_serial_be_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !packed_mode) |-> ($countones(be) == (1 << ew)));

    assert_packed_be_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && packed_mode) |-> (be[0] && (((be + 1'b1) & be) == '0)));
endmodule

// File: rtl/vls_txn_gen.sv
// Top: breaks one vector load/store command into memory-port requests,
// packed when aligned and eligible, one per element (and field) otherwise.
// Assumes elements, strides and index offsets are element-size aligned.
module vls_txn_gen
    import vls_pkg::*;
#(
    parameter int PORT_BYTES = 8,
    parameter int VLEN_BYTES = 32,
    parameter int VL_W       = 9,
    parameter int ADDR_W     = 32,
    localparam int DATA_W    = 8 * PORT_BYTES,
    localparam int LANE_W    = $clog2(PORT_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_kind,
    input  logic [1:0]         cmd_ew,
    input  logic               cmd_store,
    input  logic [VL_W-1:0]    cmd_vl,
    input  logic [ADDR_W-1:0]  cmd_base,
    input  logic [ADDR_W-1:0]  cmd_stride,
    input  logic [2:0]         cmd_nf,
    input  logic               idx_valid,
    output logic               idx_ready,
    input  logic [ADDR_W-1:0]  idx_offset,
    input  logic               st_valid,
    output logic               st_ready,
    input  logic [DATA_W-1:0]  st_data,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [PORT_BYTES-1:0] mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [VL_W-1:0]    wb_elem,
    output logic [2:0]         wb_field,
    output logic               done
);
    vls_kind_e         kind_in, kind_q;
    logic              plan_packed, busy, packed_q, store_q, is_idx, cmd_fire;
    logic [VL_W-1:0]   plan_total, elem_q, total_q;
    logic [2:0]        plan_nf, field_q;
    logic [1:0]        ew_q;
    logic [ADDR_W-1:0] base_q, cur_addr;

    // Handshake and address selection at the block edge.
    always_comb begin
        kind_in   = vls_kind_e'(cmd_kind);
        cmd_ready = !busy;
        cmd_fire  = cmd_valid && !busy;
        is_idx    = (kind_q == KIND_INDEXED);
        mem_valid = busy && (!is_idx || idx_valid) && (!store_q || st_valid);
        idx_ready = mem_valid && mem_ready && is_idx;
        st_ready  = mem_valid && mem_ready && store_q;
        mem_addr  = is_idx ? (base_q + idx_offset) : cur_addr;
        mem_we    = busy && store_q;
        wb_elem   = elem_q;
        wb_field  = field_q;
    end

    vls_plan #(.PORT_BYTES(PORT_BYTES), .VLEN_BYTES(VLEN_BYTES), .VL_W(VL_W)) u_plan (
        .kind(kind_in), .ew(cmd_ew), .vl(cmd_vl), .base_lo(cmd_base[LANE_W-1:0]),
        .nf(cmd_nf), .packed_mode(plan_packed), .total(plan_total), .nf_eff(plan_nf)
    );

    vls_seq #(.PORT_BYTES(PORT_BYTES), .VL_W(VL_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire),
        .plan_packed(plan_packed), .plan_total(plan_total), .plan_nf(plan_nf),
        .cmd_kind(kind_in), .cmd_ew(cmd_ew), .cmd_store(cmd_store),
        .cmd_base(cmd_base), .cmd_stride(cmd_stride),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .busy(busy), .packed_q(packed_q), .kind_q(kind_q), .ew_q(ew_q),
        .store_q(store_q), .base_q(base_q), .cur_addr(cur_addr),
        .elem_q(elem_q), .field_q(field_q), .total_q(total_q), .done(done)
    );

    vls_lane #(.PORT_BYTES(PORT_BYTES), .VL_W(VL_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .active(mem_valid), .packed_mode(packed_q),
        .ew(ew_q), .lane_off(mem_addr[LANE_W-1:0]), .elem(elem_q), .total(total_q),
        .store(store_q), .st_data(st_data), .be(mem_be), .wdata(mem_wdata)
    );

    assert_load_nodata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !store_q) |-> (mem_wdata == '0 && !st_ready));

    assert_idx_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_idx) |-> !idx_ready);
endmodule

// File: tb/vls_txn_gen_bench.sv
module vls_txn_gen_bench;
    localparam int PB = 8, VLB = 32, VLW = 9, AW = 32, DW = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, cmd_ready, cmd_store = 0;
    logic [2:0] cmd_kind = 0, cmd_nf = 0;
    logic [1:0] cmd_ew = 0;
    logic [VLW-1:0] cmd_vl = 0;
    logic [AW-1:0] cmd_base = 0, cmd_stride = 0, idx_offset = 0;
    logic idx_valid = 0, idx_ready, st_valid = 0, st_ready;
    logic [DW-1:0] st_data = 0, mem_wdata;
    logic mem_valid, mem_ready = 0, mem_we, done;
    logic [AW-1:0] mem_addr;
    logic [PB-1:0] mem_be;
    logic [VLW-1:0] wb_elem;
    logic [2:0] wb_field;

    int n_tests = 0, n_fail = 0;

    logic [AW-1:0]  e_addr [512];
    logic [PB-1:0]  e_be   [512];
    logic [DW-1:0]  e_data [512];
    logic [VLW-1:0] e_elem [512];
    logic [2:0]     e_field[512];
    logic [DW-1:0]  sdata  [512];
    logic [AW-1:0]  idxv   [512];
    int e_cnt;

    always #2 clk = ~clk;

    vls_txn_gen u_vls_txn_gen (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_ew(cmd_ew), .cmd_store(cmd_store), .cmd_vl(cmd_vl),
        .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_nf(cmd_nf),
        .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_offset(idx_offset),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .wb_elem(wb_elem), .wb_field(wb_field), .done(done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] bytemask(input logic [PB-1:0] be);
        logic [DW-1:0] m;
        for (int b = 0; b < PB; b++) m[b*8 +: 8] = {8{be[b]}};
        return m;
    endfunction

    // Expected request list from the requirements (R1-related widths, R2..R8, R11, R12).
    task automatic build(input int kind, input int ew, input int vl, input logic [AW-1:0] base,
                         input logic [AW-1:0] stride, input int nf, input bit store);
        int esz, epb, n, nfl;
        bit pk;
        esz = 1 << ew;
        epb = PB / esz;
        n   = (kind == 4) ? ((nf + 1) * VLB) / esz : vl;
        nfl = (kind == 3) ? nf + 1 : 1;
        pk  = (kind == 0 || kind == 4 || (kind == 3 && nf == 0)) && (base[2:0] == 3'd0);
        e_cnt = 0;
        if (pk) begin
            for (int b = 0; b * epb < n; b++) begin
                int c;
                c = (n - b * epb < epb) ? n - b * epb : epb;
                e_addr[e_cnt]  = base + AW'(b * PB);
                e_be[e_cnt]    = PB'((16'h1 << (c * esz)) - 16'h1);
                e_data[e_cnt]  = store ? (sdata[e_cnt] & bytemask(e_be[e_cnt])) : '0;
                e_elem[e_cnt]  = VLW'(b * epb);
                e_field[e_cnt] = 3'd0;
                e_cnt++;
            end
        end else begin
            for (int i = 0; i < n; i++) begin
                for (int f = 0; f < nfl; f++) begin
                    logic [AW-1:0] a;
                    logic [DW-1:0] d;
                    if (kind == 1)      a = base + AW'(i) * stride;
                    else if (kind == 2) a = base + idxv[i];
                    else                a = base + AW'((i * nfl + f) * esz);
                    d = sdata[e_cnt] & ((64'h1 << (8 * esz)) - 64'h1);
                    e_addr[e_cnt]  = a;
                    e_be[e_cnt]    = PB'(((1 << esz) - 1) << a[2:0]);
                    e_data[e_cnt]  = store ? (d << (8 * a[2:0])) : '0;
                    e_elem[e_cnt]  = VLW'(i);
                    e_field[e_cnt] = 3'(f);
                    e_cnt++;
                end
            end
        end
    endtask

    task automatic run(input int kind, input int ew, input int vl, input logic [AW-1:0] base,
                       input logic [AW-1:0] stride, input int nf, input bit store, input string tag);
        int k, cyc;
        bit prev_last, prev_stall;
        logic [AW-1:0] prev_addr;
        for (int i = 0; i < 512; i++) begin
            sdata[i] = {$urandom, $urandom};
            idxv[i]  = AW'(($urandom % 512) << ew);
        end
        build(kind, ew, vl, base, stride, nf, store);
        @(negedge clk);
        cmd_kind = 3'(kind); cmd_ew = 2'(ew); cmd_vl = VLW'(vl); cmd_base = base;
        cmd_stride = stride; cmd_nf = 3'(nf); cmd_store = store; cmd_valid = 1'b1;
        mem_ready = 1'b0; idx_valid = 1'b0; st_valid = 1'b0;
        #1;
        check(cmd_ready === 1'b1, "R10", "cmd_ready when idle", 128'(cmd_ready), 128'(1));
        k = 0; cyc = 0; prev_last = (e_cnt == 0); prev_stall = 0; prev_addr = '0;
        while ((k < e_cnt || prev_last) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            cmd_valid = 1'b0;
            mem_ready = ($urandom % 4) != 0;
            idx_valid = ($urandom % 4) != 0;
            st_valid  = ($urandom % 4) != 0;
            st_data   = sdata[k < 512 ? k : 0];
            idx_offset = idxv[(k < e_cnt) ? int'(e_elem[k]) : 0];
            #1;
            check(done === prev_last, "R10", "done pulse", 128'(done), 128'(prev_last));
            check(cmd_ready === (k >= e_cnt), "R10", "cmd_ready while busy",
                  128'(cmd_ready), 128'(k >= e_cnt));
            if (prev_stall && mem_valid)
                check(mem_addr === prev_addr, "R9", "address held under stall",
                      128'(mem_addr), 128'(prev_addr));
            prev_last = 0;
            if (mem_valid && mem_ready) begin
                if (k >= e_cnt) begin
                    check(0, tag, "extra request", 128'(mem_addr), 128'(0));
                end else begin
                    check({mem_addr, mem_be, mem_wdata, wb_elem, wb_field, mem_we} ===
                          {e_addr[k], e_be[k], e_data[k], e_elem[k], e_field[k], store},
                          tag, "request addr/be/data/elem/field/we (R1 R11 R12)",
                          {mem_addr, mem_be, mem_wdata, wb_elem, wb_field, mem_we},
                          {e_addr[k], e_be[k], e_data[k], e_elem[k], e_field[k], store});
                    if (kind == 2)
                        check(idx_ready === 1'b1, "R6", "index consumed", 128'(idx_ready), 128'(1));
                    check(st_ready === store, "R11", "store word consumed", 128'(st_ready), 128'(store));
                    k++;
                    if (k == e_cnt) prev_last = 1;
                end
            end
            prev_stall = mem_valid && !mem_ready;
            prev_addr  = mem_addr;
        end
        check(k == e_cnt, tag, "request count", 128'(k), 128'(e_cnt));
        mem_ready = 1'b0; idx_valid = 1'b0; st_valid = 1'b0;
    endtask

    function automatic string tag_of(input int kind, input logic [AW-1:0] base, input int nf);
        if (kind == 1) return "R5";
        if (kind == 2) return "R6";
        if (kind == 3) return "R7";
        if (kind == 4) return "R8";
        return (base[2:0] == 3'd0) ? "R2" : "R4";
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(mem_valid === 1'b0 && done === 1'b0 && cmd_ready === 1'b1, "R13",
              "reset outputs", {mem_valid, done, cmd_ready}, 3'b001);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(mem_valid === 1'b0 && cmd_ready === 1'b1, "R13", "after reset",
              {mem_valid, cmd_ready}, 2'b01);

        // Directed corners.
        run(0, 0, 8,  32'h1000, 0, 0, 0, "R2");          // exact beat
        run(0, 1, 13, 32'h2000, 0, 0, 1, "R3");          // tail beat, store
        run(0, 2, 3,  32'h2008, 0, 0, 1, "R3");          // tail, 32-bit
        run(0, 1, 6,  32'h3002, 0, 0, 1, "R4");          // misaligned unit
        run(1, 2, 5,  32'h0000_0004, 32'hFFFF_FFF8, 0, 1, "R5"); // wraps below zero
        run(1, 0, 7,  32'h40, 32'd3, 0, 0, "R5");
        run(2, 1, 9,  32'hFFFF_FF00, 0, 0, 1, "R6");
        run(3, 0, 12, 32'h5000, 0, 0, 0, "R7");          // single field: packed
        run(3, 1, 5,  32'h5010, 0, 2, 1, "R7");          // three fields
        run(4, 2, 99, 32'h6000, 0, 1, 1, "R8");          // whole aligned, vl ignored
        run(4, 0, 0,  32'h6003, 0, 0, 0, "R8");          // whole misaligned
        run(0, 0, 0,  32'h7000, 0, 0, 0, "R10");         // zero length
        run(0, 0, 1,  32'h7000, 0, 0, 1, "R1");

        // Constrained random commands.
        for (int t = 0; t < 60; t++) begin
            int kind, ew, vl, nf;
            logic [AW-1:0] base, stride;
            kind = $urandom % 5;
            ew   = $urandom % 3;
            vl   = ($urandom % 10 == 0) ? 0 : 1 + ($urandom % 40);
            nf   = (kind == 3) ? ($urandom % 8) : (kind == 4) ? ($urandom % 4) : 0;
            base = $urandom;
            base = ($urandom % 2) ? (base & ~32'h7) : (base & ~AW'((1 << ew) - 1));
            stride = AW'((int'($urandom % 129) - 64) * (1 << ew));
            run(kind, ew, vl, base, stride, nf, 1'($urandom % 2), tag_of(kind, base, nf));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule